// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block translates console bus addresses into cartridge ROM addresses. The CPU programs it by writing to two ports. A write to the select port picks one of eight bank registers. A write to the data port then loads that register. Six registers pick character-ROM banks for the PPU pattern tables: two 2 KB banks cover the lower table and four 1 KB banks cover the upper table. The other two registers pick the 8 KB program banks seen at CPU `$8000` and `$A000`. The two 8 KB windows from `$C000` to `$FFFF` always show the final two program banks, so the reset vector is always reachable.

Both address translations are combinational. Only the select index and the bank registers are clocked. Nametable routing is not under software control. A static mode input chooses horizontal mirroring, vertical mirroring, or four-screen operation on cartridge RAM. The parameters `PrgAw` and `ChrAw` give the address widths of the fitted ROMs. A bank number beyond the fitted size wraps onto the smaller ROM.

Top module: `bankMapper`

## Requirements
- R1: A write strobe (`cpuWrite` high at a rising clock edge) to an even address in `$8000`-`$9FFF` loads `cpuData[2:0]` into the select index. `cpuData[7:3]` is ignored.
- R2: A write strobe to an odd address in `$8000`-`$9FFF` loads `cpuData[5:0]` into the bank register chosen by the select index. The upper data bits are dropped.
- R3: For PPU `$0000`-`$0FFF`, register 0 (`ppuAddr[11]`=0) or register 1 (`ppuAddr[11]`=1) supplies a 2 KB bank. The full address is `{reg[5:1], ppuAddr[10:0]}`, so the register's bit 0 has no effect.
- R4: For PPU `$1000`-`$1FFF`, register `2+ppuAddr[11:10]` supplies a 1 KB bank. The full address is `{reg[5:0], ppuAddr[9:0]}`.
- R5: CPU `$8000`-`$9FFF` uses register 6 and CPU `$A000`-`$BFFF` uses register 7. The full program address is `{reg[3:0], cpuAddr[12:0]}`, so register bits 5:4 are ignored.
- R6: CPU `$C000`-`$DFFF` maps to bank 14 (second to last) and CPU `$E000`-`$FFFF` maps to bank 15 (last) of a full 128 KB ROM, regardless of any register.
- R7: Write strobes to `$A000`-`$FFFF` change neither the select index nor any bank register. Bus activity without `cpuWrite` also changes nothing.
- R8: With `rstN` low, the select index and all eight bank registers are cleared to zero.
- R9: When `ppuAddr[13]`=1, mode 0 (horizontal) drives `ciramA10` from `ppuAddr[11]` and mode 1 (vertical) drives it from `ppuAddr[10]`. In both modes `ciramSel` is high. Mode 2 or 3 (four-screen) raises `cartVramSel` instead of `ciramSel`.
- R10: `prgSel` is high exactly when `cpuAddr[15]`=1. `chrSel` is high exactly when `ppuAddr[13]`=0.
- R11: `prgAddr` and `chrAddr` are the low `PrgAw` and `ChrAw` bits of the full 17-bit and 16-bit addresses. Bank numbers therefore wrap on a smaller ROM, and the fixed windows land on that ROM's last two banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | CPU address bus |
| cpuData | input | 8 | CPU write data |
| cpuWrite | input | 1 | One-cycle CPU write strobe |
| ppuAddr | input | 14 | PPU address bus |
| mirrorMode | input | 2 | Static nametable mode: 0 horizontal, 1 vertical, 2/3 four-screen |
| prgAddr | output | PrgAw | Program ROM address |
| prgSel | output | 1 | Program ROM enable |
| chrAddr | output | ChrAw | Character ROM address |
| chrSel | output | 1 | Character ROM enable |
| ciramA10 | output | 1 | Console nametable RAM bank line |
| ciramSel | output | 1 | Console nametable RAM enable |
| cartVramSel | output | 1 | Cartridge nametable RAM enable (four-screen) |

## Verification
Each bank register is loaded with a distinct value that sets its upper bits. A value that has only been truncated correctly can then be told apart from one sent to the wrong window, or from a bit that should have been masked but leaked through. Select writes carry junk in bits 7:3, and data writes appear at the very end of the decode window (`$9FFE`/`$9FFF`). Writes to `$A000`-`$FFFF` and address activity without a strobe are then shown to leave every mapping intact. This separates a correct decode from one that looks only at `A15` or ignores `A0`. A second instance built with a 32 KB program ROM and an 8 KB character ROM is read through the same accesses to expose the wrap-around of bank numbers. Each of the three mirroring modes is also probed with nametable addresses in which `A10` and `A11` differ.

// File: rtl/mapperPkg.sv
package mapperPkg;

  localparam int NumBanks  = 8;
  localparam int IdxW      = $clog2(NumBanks);
  localparam int BankValW  = 6;
  localparam int PrgBankW  = 4;
  localparam int PrgFullW  = PrgBankW + 13;
  localparam int ChrFullW  = BankValW + 10;

  typedef enum logic [1:0] {
    MIR_HORZ  = 2'd0,
    MIR_VERT  = 2'd1,
    MIR_FOUR  = 2'd2,
    MIR_FOUR2 = 2'd3
  } mirrorT;

  typedef struct packed {
    logic       selWr;
    logic       dataWr;
    logic [7:0] wrData;
  } regStrobeT;

endpackage

// File: rtl/mapperRegCtrl.sv
module mapperRegCtrl
  import mapperPkg::*;
(
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuData,
  input  logic        cpuWrite,
  output regStrobeT   strobe
);

  logic inWindow;

  // Decode uses A15..A13 for the window and A0 for port choice
  assign inWindow = (cpuAddr[15:13] == 3'b100);

  always_comb begin
    strobe        = '0;
    strobe.wrData = cpuData;
    if (cpuWrite && inWindow) begin
      strobe.selWr  = ~cpuAddr[0];
      strobe.dataWr = cpuAddr[0];
    end
  end

endmodule

// File: rtl/mapperBankRegs.sv
module mapperBankRegs
  import mapperPkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  regStrobeT                          strobe,
  output logic [IdxW-1:0]                    selIdx,
  output logic [NumBanks-1:0][BankValW-1:0]  banks
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              selIdx <= '0;
    else if (strobe.selWr)  selIdx <= strobe.wrData[IdxW-1:0];
  end

  for (genvar g = 0; g < NumBanks; g++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        banks[g] <= '0;
      else if (strobe.dataWr && (selIdx == IdxW'(g)))
        banks[g] <= strobe.wrData[BankValW-1:0];
    end
  end

endmodule

// File: rtl/mapperXlate.sv
module mapperXlate
  import mapperPkg::*;
#(
  parameter int PrgAw = 17,
  parameter int ChrAw = 16
) (
  input  logic [NumBanks-1:0][BankValW-1:0] banks,
  input  logic [15:0]                       cpuAddr,
  input  logic [13:0]                       ppuAddr,
  input  logic [1:0]                        mirrorMode,
  output logic [PrgAw-1:0]                  prgAddr,
  output logic                              prgSel,
  output logic [ChrAw-1:0]                  chrAddr,
  output logic                              chrSel,
  output logic                              ciramA10,
  output logic                              ciramSel,
  output logic                              cartVramSel
);

  logic [PrgBankW-1:0] prgBank;
  logic [PrgFullW-1:0] prgFull;
  logic [BankValW-1:0] chrBank;
  logic [ChrFullW-1:0] chrFull;
  logic                isNameTable;
  mirrorT              mode;

  // Program side: two switchable windows, two fixed at the top
  always_comb begin
    unique case (cpuAddr[14:13])
      2'b00:   prgBank = banks[6][PrgBankW-1:0];
      2'b01:   prgBank = banks[7][PrgBankW-1:0];
      2'b10:   prgBank = {{(PrgBankW-1){1'b1}}, 1'b0};
      default: prgBank = {PrgBankW{1'b1}};
    endcase
  end

  assign prgFull = {prgBank, cpuAddr[12:0]};
  assign prgAddr = prgFull[PrgAw-1:0];
  assign prgSel  = cpuAddr[15];

  // Character side: 2 KB pair below $1000, 1 KB quad above
  always_comb begin
    if (!ppuAddr[12]) begin
      chrBank = {banks[ppuAddr[11]][BankValW-1:1], ppuAddr[10]};
    end else begin
      chrBank = banks[{1'b0, ppuAddr[11:10]} + 3'd2];
    end
  end

  assign chrFull = {chrBank, ppuAddr[9:0]};
  assign chrAddr = chrFull[ChrAw-1:0];
  assign chrSel  = ~ppuAddr[13];

  // Fixed nametable routing
  assign isNameTable = ppuAddr[13];
  assign mode        = mirrorT'(mirrorMode);

  always_comb begin
    ciramA10    = ppuAddr[10];
    ciramSel    = 1'b0;
    cartVramSel = 1'b0;
    unique case (mode)
      MIR_HORZ: begin
        ciramA10 = ppuAddr[11];
        ciramSel = isNameTable;
      end
      MIR_VERT: begin
        ciramA10 = ppuAddr[10];
        ciramSel = isNameTable;
      end
      default: cartVramSel = isNameTable;
    endcase
  end

endmodule

// File: rtl/bankMapper.sv
module bankMapper
  import mapperPkg::*;
#(
  parameter int PrgAw = 17,
  parameter int ChrAw = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic              cpuWrite,
  input  logic [13:0]       ppuAddr,
  input  logic [1:0]        mirrorMode,
  output logic [PrgAw-1:0]  prgAddr,
  output logic              prgSel,
  output logic [ChrAw-1:0]  chrAddr,
  output logic              chrSel,
  output logic              ciramA10,
  output logic              ciramSel,
  output logic              cartVramSel
);

  if (PrgAw < 14 || PrgAw > PrgFullW) begin : g_badPrg
    $error("PrgAw out of range");
  end
  if (ChrAw < 10 || ChrAw > ChrFullW) begin : g_badChr
    $error("ChrAw out of range");
  end

  regStrobeT                          strobe;
  logic [IdxW-1:0]                    selIdx;
  logic [NumBanks-1:0][BankValW-1:0]  banks;

  mapperRegCtrl i_ctrl (
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .cpuWrite(cpuWrite),
    .strobe  (strobe)
  );

  mapperBankRegs i_regs (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .selIdx(selIdx),
    .banks (banks)
  );

  mapperXlate #(.PrgAw(PrgAw), .ChrAw(ChrAw)) i_xlate (
    .banks      (banks),
    .cpuAddr    (cpuAddr),
    .ppuAddr    (ppuAddr),
    .mirrorMode (mirrorMode),
    .prgAddr    (prgAddr),
    .prgSel     (prgSel),
    .chrAddr    (chrAddr),
    .chrSel     (chrSel),
    .ciramA10   (ciramA10),
    .ciramSel   (ciramSel),
    .cartVramSel(cartVramSel)
  );

endmodule

// File: rtl/mapperChecker.sv
module mapperChecker
  import mapperPkg::*;
#(
  parameter int PrgAw = 17,
  parameter int ChrAw = 16
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [15:0]                       cpuAddr,
  input logic [7:0]                        cpuData,
  input logic                              cpuWrite,
  input logic [13:0]                       ppuAddr,
  input logic [PrgAw-1:0]                  prgAddr,
  input logic [ChrAw-1:0]                  chrAddr,
  input logic [IdxW-1:0]                   selIdx,
  input logic [NumBanks-1:0][BankValW-1:0] banks
);

  logic lowWin, highWr;
  assign lowWin = cpuWrite && cpuAddr[15] && !cpuAddr[14] && !cpuAddr[13];
  assign highWr = cpuWrite && cpuAddr[15] && (cpuAddr[14] || cpuAddr[13]);

  assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lowWin && !cpuAddr[0]) |=> (selIdx == $past(cpuData[2:0])));

  assert_data_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lowWin && cpuAddr[0]) |=> (banks[$past(selIdx)] == $past(cpuData[5:0])));

  assert_high_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    highWr |=> ($stable(banks) && $stable(selIdx)));

  assert_fixed_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:14] == 2'b11) |->
      ((&prgAddr[PrgAw-1:14]) && (prgAddr[13] == cpuAddr[13])
       && (prgAddr[12:0] == cpuAddr[12:0])));

  assert_twok_offset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ppuAddr[13:12] == 2'b00) |-> (chrAddr[10:0] == ppuAddr[10:0]));

  assert_onek_offset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ppuAddr[13:12] == 2'b01) |-> (chrAddr[9:0] == ppuAddr[9:0]));

endmodule

bind bankMapper mapperChecker #(.PrgAw(PrgAw), .ChrAw(ChrAw)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuAddr (cpuAddr),
  .cpuData (cpuData),
  .cpuWrite(cpuWrite),
  .ppuAddr (ppuAddr),
  .prgAddr (prgAddr),
  .chrAddr (chrAddr),
  .selIdx  (selIdx),
  .banks   (banks)
);

// File: tb/test_bankMapper.sv
module test_bankMapper;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWrite = 1'b0;
  logic [13:0] ppuAddr = '0;
  logic [1:0]  mirrorMode = 2'd0;

  logic [16:0] prgAddr;
  logic        prgSel;
  logic [15:0] chrAddr;
  logic        chrSel;
  logic        ciramA10, ciramSel, cartVramSel;

  logic [14:0] prgSmall;
  logic [12:0] chrSmall;
  logic        sPrgSel, sChrSel, sA10, sCiram, sCart;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  bankMapper i_bankMapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWrite(cpuWrite), .ppuAddr(ppuAddr), .mirrorMode(mirrorMode),
    .prgAddr(prgAddr), .prgSel(prgSel), .chrAddr(chrAddr), .chrSel(chrSel),
    .ciramA10(ciramA10), .ciramSel(ciramSel), .cartVramSel(cartVramSel)
  );

  bankMapper #(.PrgAw(15), .ChrAw(13)) i_bankMapperSmall (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWrite(cpuWrite), .ppuAddr(ppuAddr), .mirrorMode(mirrorMode),
    .prgAddr(prgSmall), .prgSel(sPrgSel), .chrAddr(chrSmall), .chrSel(sChrSel),
    .ciramA10(sA10), .ciramSel(sCiram), .cartVramSel(sCart)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWrite = 1'b1;
    @(negedge clk);
    cpuWrite = 1'b0; cpuAddr = 16'h0000;
  endtask

  task automatic setReg(input int idx, input logic [7:0] v);
    busWrite(16'h8000, 8'(idx));
    busWrite(16'h8001, v);
  endtask

  task automatic prgIs(input string tag, input logic [15:0] a, input int exp);
    cpuAddr = a; #1;
    check(tag, int'(prgAddr), exp);
  endtask

  task automatic chrIs(input string tag, input logic [13:0] a, input int exp);
    ppuAddr = a; #1;
    check(tag, int'(chrAddr), exp);
  endtask

  task automatic testReset();
    prgIs("R8 reset 8000", 16'h8123, 32'h00123);
    prgIs("R8 reset A000", 16'hA456, 32'h00456);
    chrIs("R8 reset chr0", 14'h0321, 32'h0321);
    chrIs("R8 reset chr1C00", 14'h1C21, 32'h0021);
    prgIs("R6 reset C000", 16'hC000, 32'h1C000);
    prgIs("R6 reset FFFC", 16'hFFFC, 32'h1FFFC);
  endtask

  task automatic testPrgBanks();
    busWrite(16'h8000, 8'hFE);           // R1: bits 7:3 junk, index 6
    busWrite(16'h8001, 8'hC5);           // R2/R5: low 4 bits 5
    prgIs("R5 reg6 8000", 16'h8123, (5 << 13) | 32'h123);
    setReg(7, 8'h3A);
    prgIs("R5 reg7 A000", 16'hBFFF, (32'hA << 13) | 32'h1FFF);
    prgIs("R6 fixed C000 after writes", 16'hD001, 32'h1D001);
    prgIs("R6 fixed E000 after writes", 16'hE002, 32'h1E002);
  endtask

  task automatic testChrBanks();
    setReg(0, 8'h07);
    chrIs("R3 reg0 lsb ignored lo", 14'h0000, 32'h1800);
    chrIs("R3 reg0 lsb ignored hi", 14'h0400, 32'h1C00);
    setReg(1, 8'hFF);
    chrIs("R3 reg1 top", 14'h0FFF, 32'hFFFF);
    chrIs("R3 reg1 base", 14'h0800, 32'hF800);
    setReg(2, 8'h11);
    setReg(3, 8'h22);
    setReg(4, 8'h33);
    setReg(5, 8'h3F);
    chrIs("R4 reg2", 14'h1155, (32'h11 << 10) | 32'h155);
    chrIs("R4 reg3", 14'h1555, (32'h22 << 10) | 32'h155);
    chrIs("R4 reg4", 14'h1955, (32'h33 << 10) | 32'h155);
    chrIs("R4 reg5", 14'h1FFF, 32'hFFFF);
  endtask

  task automatic testDecode();
    // index is 5 now; writes above the window must not move it or any bank
    busWrite(16'hA000, 8'h02);
    busWrite(16'hA001, 8'h2A);
    busWrite(16'hC001, 8'h01);
    busWrite(16'hE001, 8'h00);
    chrIs("R7 reg2 untouched", 14'h1000, 32'h11 << 10);
    chrIs("R7 reg5 untouched", 14'h1C00, 32'h3F << 10);
    chrIs("R7 reg0 untouched", 14'h0000, 32'h1800);
    // index still 5 -> this data write lands in reg5
    busWrite(16'h8001, 8'h04);
    chrIs("R7 index kept", 14'h1C00, 32'h04 << 10);
    // no strobe: address and data on bus but cpuWrite low
    @(negedge clk);
    cpuAddr = 16'h8001; cpuData = 8'h3E;
    @(negedge clk);
    chrIs("R7 no strobe", 14'h1C00, 32'h04 << 10);
    // top edge of the window
    busWrite(16'h9FFE, 8'h07);
    busWrite(16'h9FFF, 8'h09);
    prgIs("R1 R2 window edge", 16'hA000, 32'h9 << 13);
  endtask

  task automatic testEnables();
    cpuAddr = 16'h7FFF; #1; check("R10 prgSel low", int'(prgSel), 0);
    cpuAddr = 16'h8000; #1; check("R10 prgSel high", int'(prgSel), 1);
    ppuAddr = 14'h1FFF; #1; check("R10 chrSel high", int'(chrSel), 1);
    ppuAddr = 14'h2000; #1; check("R10 chrSel low", int'(chrSel), 0);
  endtask

  task automatic testMirror();
    mirrorMode = 2'd0;
    ppuAddr = 14'h2800; #1; check("R9 horz a10 set", int'(ciramA10), 1);
    ppuAddr = 14'h2400; #1; check("R9 horz a10 clr", int'(ciramA10), 0);
    check("R9 horz ciramSel", int'(ciramSel), 1);
    mirrorMode = 2'd1;
    ppuAddr = 14'h2400; #1; check("R9 vert a10 set", int'(ciramA10), 1);
    ppuAddr = 14'h2800; #1; check("R9 vert a10 clr", int'(ciramA10), 0);
    mirrorMode = 2'd2; #1;
    check("R9 four cart", int'(cartVramSel), 1);
    check("R9 four ciram off", int'(ciramSel), 0);
    ppuAddr = 14'h0800; #1;
    check("R9 pattern no ram", int'(cartVramSel | ciramSel), 0);
    mirrorMode = 2'd0;
  endtask

  task automatic testWrap();
    // reg6=5 (mod 4 -> 1), reg2=0x11 (mod 8 -> 1)
    cpuAddr = 16'h8123; #1;
    check("R11 small prg reg6", int'(prgSmall), (1 << 13) | 32'h123);
    cpuAddr = 16'hC010; #1;
    check("R11 small prg C000", int'(prgSmall), 32'h4010);
    cpuAddr = 16'hE010; #1;
    check("R11 small prg E000", int'(prgSmall), 32'h6010);
    ppuAddr = 14'h1155; #1;
    check("R11 small chr reg2", int'(chrSmall), 32'h555);
  endtask

  task automatic testReReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    prgIs("R8 rereset reg6", 16'h8010, 32'h10);
    chrIs("R8 rereset reg5", 14'h1C00, 0);
    busWrite(16'h8001, 8'h03);           // index cleared to 0
    chrIs("R8 index zero", 14'h0000, 32'h0800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPrgBanks();
    testChrBanks();
    testDecode();
    testEnables();
    testMirror();
    testWrap();
    testReReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule